// File: doc/BRIEF.md
# Chained Up/Down Counter with Terminal Count

This block is a synchronous binary counter of parameterised width. It counts up or down by one per clock edge while enabled. Its next-state logic is a ripple of small carry stages, two bits each with a single-bit stage on top when the width is odd. The carry meaning depends on the direction. Counting up, a high carry asks the next bit to toggle and moves on as carry AND bit. Counting down, a high carry means "no borrow": a bit toggles on a low carry, and the carry moves on as carry OR bit.

The enable enters the chain as the carry into the lowest stage: the enable itself when counting up, and its inverse when counting down. An input can flip the polarity of the count enable. The terminal-count flag is derived from the carry that leaves the top stage, with no comparator. No data stream flows through the block, so every pin is a plain level control or status signal and there is no valid/ready handshake.

Top module: `udc_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `count` becomes zero, whatever the enable and direction.
- R2: With the effective enable active and `up`=1, each edge sets `count` to its previous value plus one, modulo 2^WIDTH.
- R3: With the effective enable active and `up`=0, each edge sets `count` to its previous value minus one, modulo 2^WIDTH.
- R4: With the effective enable inactive, `count` keeps its value across edges.
- R5: The effective enable is `cnt_en` when `en_inv`=0 and NOT `cnt_en` when `en_inv`=1.
- R6: With `up`=1, `tc` is high exactly when the effective enable is active and `count` is all ones.
- R7: With `up`=0, `tc` is high exactly when the effective enable is active and `count` is zero.
- R8: `tc` is low whenever the effective enable is inactive, in both directions.
- R9: Counting up from all ones gives zero, and counting down from zero gives all ones.
- R10: A change of `up` takes effect at the very next edge, with no lost or stalled cycle.
- R11: `tc` is combinational: it follows the present `count`, `up` and enable inputs within the same cycle.
- R12: The behaviour above holds for odd widths, where the top stage is a single bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| cnt_en | input | 1 | Count enable, polarity set by `en_inv` |
| en_inv | input | 1 | 1 makes `cnt_en` active low |
| up | input | 1 | Direction: 1 increments, 0 decrements |
| count | output | WIDTH | Current counter value |
| tc | output | 1 | Terminal count from the top carry-out |

## Verification
The bench goes after both wrap points. A chain that injects the enable with the wrong sense for down-counting either holds at zero or jumps by the wrong amount there. It flips direction on consecutive cycles, so a stale direction in any stage would show as a double step or a miss, and it toggles the enable polarity so an inverted enable would count while idle. It checks `tc` on all-ones and zero in both directions and with the enable off, and it runs an odd-width copy. A top single-bit stage wired as a pair would corrupt the high bit or the flag.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  // Next value of one bit: toggles on a high carry counting up and on a low
  // carry counting down.
  function automatic logic bit_next(input logic q, input logic cin, input logic up);
    return q ^ cin ^ ~up;
  endfunction

  // Carry handed to the bit above.
  function automatic logic carry_next(input logic q, input logic cin, input logic up);
    return up ? (cin & q) : (cin | q);
  endfunction

  // Carry injected at the bottom of the chain.
  function automatic logic carry_inject(input logic en, input logic up);
    return up ? en : ~en;
  endfunction

endpackage

// File: rtl/udc_carry_stage.sv
module udc_carry_stage
  import udc_pkg::*;
#(
  parameter int BITS = 2
) (
  input  logic            up,
  input  logic            cin,
  input  logic [BITS-1:0] q,
  output logic [BITS-1:0] d,
  output logic            cout
);

  generate
    if (BITS == 1) begin : g_single
      always_comb begin
        d[0] = bit_next(q[0], cin, up);
        cout = carry_next(q[0], cin, up);
      end
    end else begin : g_multi
      logic [BITS:0] c;
      always_comb begin
        c[0] = cin;
        for (int b = 0; b < BITS; b++) begin
          d[b]   = bit_next(q[b], c[b], up);
          c[b+1] = carry_next(q[b], c[b], up);
        end
        cout = c[BITS];
      end
    end
  endgenerate

endmodule

// File: rtl/udc_carry_chain.sv
module udc_carry_chain
  import udc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             up,
  input  logic             en,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] d,
  output logic             cout
);

  localparam int NSTAGE = (WIDTH + 1) / 2;
  localparam bit ODD    = (WIDTH % 2) == 1;

  logic [NSTAGE:0] carry;

  assign carry[0] = carry_inject(en, up);
  assign cout     = carry[NSTAGE];

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int SB = (ODD && (s == NSTAGE - 1)) ? 1 : 2;
    udc_carry_stage #(.BITS(SB)) u_stage (
      .up  (up),
      .cin (carry[s]),
      .q   (q[2*s +: SB]),
      .d   (d[2*s +: SB]),
      .cout(carry[s+1])
    );
  end

endmodule

// File: rtl/udc_counter.sv
module udc_counter
  import udc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             en_inv,
  input  logic             up,
  output logic [WIDTH-1:0] count,
  output logic             tc
);

  logic             en_eff;
  logic [WIDTH-1:0] count_d;
  logic             chain_cout;
  dir_e             dir;

  assign en_eff = cnt_en ^ en_inv;
  assign dir    = dir_e'(up);

  udc_carry_chain #(.WIDTH(WIDTH)) u_chain (
    .up  (up),
    .en  (en_eff),
    .q   (count),
    .d   (count_d),
    .cout(chain_cout)
  );

  // Counting down, the top carry is low only on an enabled borrow out of zero.
  assign tc = (dir == DIR_UP) ? chain_cout : ~chain_cout;

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count_d;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (count == '0)); // R1
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (en_eff && up) |=> (count == WIDTH'($past(count) + 1'b1))); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (en_eff && !up) |=> (count == WIDTH'($past(count) - 1'b1))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en_eff |=> $stable(count)); // R4
  AST_TC_UP: assert property (@(posedge clk) disable iff (rst)
    (up && tc) |-> (&count)); // R6
  AST_TC_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!up && tc) |-> (count == '0)); // R7
  AST_TC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en_eff |-> !tc); // R8

endmodule

// File: tb/udc_counter_bench.sv
module udc_counter_bench;

  localparam int WA = 8;
  localparam int WB = 5;

  logic          clk = 1'b0;
  logic          rst, cnt_en, en_inv, up;
  logic [WA-1:0] count_a;
  logic [WB-1:0] count_b;
  logic          tc_a, tc_b;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int mod_a, mod_b;

  always #4 clk = ~clk;

  udc_counter #(.WIDTH(WA)) u_udc_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .en_inv(en_inv), .up(up),
    .count(count_a), .tc(tc_a));

  udc_counter #(.WIDTH(WB)) u_udc_counter_odd (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .en_inv(en_inv), .up(up),
    .count(count_b), .tc(tc_b));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not end (actual hung, expected finish)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int step(input int v, input int w, input logic r,
                              input logic e, input logic u);
    int m = (1 << w) - 1;
    if (r) return 0;
    if (!e) return v;
    return u ? ((v + 1) & m) : ((v - 1) & m);
  endfunction

  function automatic logic tc_model(input int v, input int w, input logic e,
                                    input logic u);
    if (!e) return 1'b0;
    return u ? (v == (1 << w) - 1) : (v == 0);
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check tc, then after the edge check count.
  task automatic cycle(input logic r, input logic e, input logic inv,
                       input logic u, input string req);
    logic eff;
    @(negedge clk);
    rst = r; cnt_en = e; en_inv = inv; up = u;
    eff = e ^ inv;
    #1;
    chk(int'(tc_a), int'(tc_model(mod_a, WA, eff, u)), {req, " tc R11"});
    chk(int'(tc_b), int'(tc_model(mod_b, WB, eff, u)), {req, " tc R12"});
    mod_a = step(mod_a, WA, r, eff, u);
    mod_b = step(mod_b, WB, r, eff, u);
    @(posedge clk);
    #1;
    chk(int'(count_a), mod_a, {req, " count"});
    chk(int'(count_b), mod_b, {req, " count R12"});
  endtask

  initial begin
    string tag;
    logic r, e, inv, u;
    rst = 1'b1; cnt_en = 1'b0; en_inv = 1'b0; up = 1'b1;
    mod_a = 0; mod_b = 0;
    void'($urandom(32'd20250));
    @(posedge clk); #1;
    chk(int'(count_a), 0, "R1 reset state");
    chk(int'(count_b), 0, "R1 reset state R12");

    // R1: reset wins over enable
    cycle(1'b1, 1'b1, 1'b0, 1'b1, "R1");
    // R3/R9: borrow out of zero to all ones, tc seen at zero going down (R7)
    cycle(1'b0, 1'b1, 1'b0, 1'b0, "R3 R7 R9 down wrap");
    // R6: at all ones counting up
    cycle(1'b0, 1'b0, 1'b0, 1'b1, "R4 R8 idle at all ones");
    cycle(1'b0, 1'b1, 1'b0, 1'b1, "R2 R6 R9 up wrap");
    // R10: alternate direction every cycle
    for (int i = 0; i < 6; i++)
      cycle(1'b0, 1'b1, 1'b0, logic'(i[0]), "R10 direction flip");
    // R5: inverted polarity, cnt_en low counts, high holds
    cycle(1'b0, 1'b0, 1'b1, 1'b1, "R5 active-low enable counts");
    cycle(1'b0, 1'b1, 1'b1, 1'b1, "R5 active-low enable idle R4");
    // walk the full range up then down
    for (int i = 0; i < (1 << WA) + 2; i++)
      cycle(1'b0, 1'b1, 1'b0, 1'b1, "R2 full sweep up");
    for (int i = 0; i < (1 << WA) + 2; i++)
      cycle(1'b0, 1'b0, 1'b1, 1'b0, "R3 R5 full sweep down");

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      r   = ($urandom % 64) == 0;
      e   = ($urandom % 4) != 0;
      inv = ($urandom % 8) == 0;
      u   = ($urandom % 16) < 9;
      tag = r ? "R1 random" : ((e ^ inv) ? (u ? "R2 random" : "R3 random") : "R4 random");
      cycle(r, e, inv, u, tag);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule